// File: doc/BRIEF.md
# Write Gather Buffer with Pulse Timeout

This block sits between an on-chip bus master and an outbound memory fabric. It collects successive beat-sized writes that fall in the same line and share one transaction type into a single line buffer, merging their byte enables. It then releases the whole line as one outbound write. A release happens when every byte of the line has been written, when a new write cannot join the open line, when another master probes the open line for a read, or when a coarse timeout expires.

The timeout does not count clock cycles. A free-running prescaler produces one tick every `PULSE_PERIOD` cycles, and a per-slave 3-bit code selects how many ticks may pass after the last gathered write. Because the tick phase is unrelated to write arrival, expiry lands within one tick period of the nominal value. Cache-inhibited partial writes are never merged: each one leaves as its own outbound write, marked as a bypass.

Addresses are in beats: `wr_addr` selects one `BEAT_BYTES`-wide beat, and its low `log2(LINE_WORDS)` bits pick the beat within the line. Probe and flush addresses are line addresses.

Top module: `write_gather`

## Requirements
- R1: In the first cycle after synchronous reset, `fl_valid`, `pending`, `busy` and `rd_hold` are 0 and `wr_ready` is 1.
- R2: Accepted writes of equal line and equal type merge into one buffer. Line byte i = beat (i / BEAT_BYTES), byte (i mod BEAT_BYTES), and it sits at `fl_data[8i+7:8i]` and `fl_mask[i]`. The flushed mask is the OR of every gathered byte enable, and each masked byte holds the last value written to it.
- R3: When an accepted write completes the mask of the line, `fl_valid` rises in the next cycle.
- R4: While data is pending, a write to a different line, or with a different type, sees `wr_ready` = 0. The pending line flushes first, and the write is accepted after the flush is acknowledged.
- R5: A write of type 4 (cache-inhibited partial write) is never merged. It is accepted only when no data is pending, and `fl_valid` rises the next cycle with `fl_bypass` = 1 and a mask holding only its own bytes. If data is pending, that data flushes first.
- R6: The prescaler counts from 0 after reset and ticks in every cycle where its count equals `PULSE_PERIOD`-1. Timeout codes 4, 5, 6 and 7 allow 2, 4, 8 and 16 ticks. The code is sampled when each gathered write is accepted, and that accept restarts the countdown. `fl_valid` rises in the cycle after the last allowed tick.
- R7: Timeout codes 1, 2 and 3 behave exactly like code 4.
- R8: With timeout code 0, gathered data stays pending indefinitely until another flush condition occurs.
- R9: `rd_hold` is 1 while `rd_valid` is high and `rd_line` equals the line that is pending or being flushed. A hit on a pending line starts a flush in the next cycle. A probe of any other line has no effect.
- R10: While `fl_valid` is 1 and `fl_ready` is 0, all flush outputs stay unchanged, `busy` stays 1 and `wr_ready` is 0. The cycle after `fl_ready` is seen, the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tmo | input | 3 | Timeout code |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted this cycle |
| wr_addr | input | ADDR_W | Beat address of the write |
| wr_data | input | BEAT_BYTES*8 | Write data |
| wr_be | input | BEAT_BYTES | Write byte enables |
| wr_ttype | input | 3 | Write transaction type |
| rd_valid | input | 1 | Read probe from another master |
| rd_line | input | ADDR_W-log2(LINE_WORDS) | Line address of the probe |
| rd_hold | output | 1 | Probe must wait for a flush |
| fl_valid | output | 1 | Outbound write valid |
| fl_ready | input | 1 | Outbound write acknowledged |
| fl_line | output | ADDR_W-log2(LINE_WORDS) | Line address of the outbound write |
| fl_data | output | LINE_WORDS*BEAT_BYTES*8 | Gathered line data |
| fl_mask | output | LINE_WORDS*BEAT_BYTES | Gathered byte mask |
| fl_ttype | output | 3 | Transaction type of the outbound write |
| fl_bypass | output | 1 | Outbound write was an ungathered type 4 write |
| pending | output | 1 | Gathered data waiting in the buffer |
| busy | output | 1 | Buffer not idle (pending or flushing) |

## Verification
A countdown loaded with the wrong value, or decremented on the wrong tick, moves the rise of `fl_valid` by a whole tick period (64 cycles). The per-cycle model catches this on the first cycle it differs. A corrupted mask or line tag shows on `fl_mask` or `fl_line` in the first flush cycle. It also shows sooner as a wrong `wr_ready` or `rd_hold`, in the same cycle that a conflicting write or probe arrives. A state machine stuck in flush shows as `wr_ready` held low, and a stuck gather shows as `pending` lasting past the longest timeout.

// File: rtl/wg_pkg.sv
`timescale 1ns/1ps
package wg_pkg;

  typedef enum logic [1:0] {
    WG_IDLE   = 2'd0,
    WG_GATHER = 2'd1,
    WG_FLUSH  = 2'd2
  } wg_state_e;

  // transaction type that must never be merged
  localparam logic [2:0] TT_CI = 3'd4;

  // tick count register width, enough for the longest setting of 16
  localparam int TICK_W = 5;
  localparam int MAX_TICKS = 16;

  function automatic logic [TICK_W-1:0] tick_limit(input logic [2:0] code);
    case (code)
      3'd0:    return TICK_W'(0);
      3'd5:    return TICK_W'(4);
      3'd6:    return TICK_W'(8);
      3'd7:    return TICK_W'(16);
      default: return TICK_W'(2);
    endcase
  endfunction

endpackage

// File: rtl/wg_prescaler.sv
`timescale 1ns/1ps
module wg_prescaler #(
  parameter int PERIOD = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (cnt_q == CW'(PERIOD - 1)) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == CW'(PERIOD - 1));
endmodule

// File: rtl/wg_timeout.sv
`timescale 1ns/1ps
module wg_timeout
  import wg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [2:0] code,
  input  logic       tick,
  input  logic       active,
  output logic       expire
);
  logic [TICK_W-1:0] left_q;
  logic              en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      en_q   <= 1'b0;
    end else if (load) begin
      left_q <= tick_limit(code);
      en_q   <= (code != 3'd0);
    end else if (active && tick && en_q && left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign expire = active && tick && en_q && (left_q == TICK_W'(1));
endmodule

// File: rtl/wg_line_buf.sv
`timescale 1ns/1ps
module wg_line_buf #(
  parameter int BEAT_BYTES = 8,
  parameter int LINE_WORDS = 4
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  clear,
  input  logic                                  wr_en,
  input  logic [$clog2(LINE_WORDS)-1:0]         word_sel,
  input  logic [BEAT_BYTES*8-1:0]               wr_data,
  input  logic [BEAT_BYTES-1:0]                 wr_be,
  output logic [LINE_WORDS*BEAT_BYTES*8-1:0]    line_data,
  output logic [LINE_WORDS*BEAT_BYTES-1:0]      line_mask,
  output logic [LINE_WORDS*BEAT_BYTES-1:0]      mask_next
);
  localparam int DATA_W     = BEAT_BYTES * 8;
  localparam int LINE_BYTES = LINE_WORDS * BEAT_BYTES;
  localparam int WSEL_W     = $clog2(LINE_WORDS);

  logic [DATA_W-1:0]     mem [LINE_WORDS];
  logic [LINE_BYTES-1:0] mask_q;
  logic [LINE_BYTES-1:0] set_v;

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    for (genvar b = 0; b < BEAT_BYTES; b++) begin : g_byte
      assign set_v[w*BEAT_BYTES + b] = wr_en && (word_sel == WSEL_W'(w)) && wr_be[b];
    end
    assign line_data[w*DATA_W +: DATA_W] = mem[w];
  end

  // byte-enabled write into a small word array
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BEAT_BYTES; b++) begin
        if (wr_be[b]) mem[word_sel][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) mask_q <= '0;
    else mask_q <= mask_q | set_v;
  end

  assign line_mask = mask_q;
  assign mask_next = mask_q | set_v;
endmodule

// File: rtl/write_gather.sv
`timescale 1ns/1ps
module write_gather
  import wg_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int BEAT_BYTES   = 8,
  parameter int LINE_WORDS   = 4,
  parameter int PULSE_PERIOD = 64
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic [2:0]                                 cfg_tmo,
  input  logic                                       wr_valid,
  output logic                                       wr_ready,
  input  logic [ADDR_W-1:0]                          wr_addr,
  input  logic [BEAT_BYTES*8-1:0]                    wr_data,
  input  logic [BEAT_BYTES-1:0]                      wr_be,
  input  logic [2:0]                                 wr_ttype,
  input  logic                                       rd_valid,
  input  logic [ADDR_W-$clog2(LINE_WORDS)-1:0]       rd_line,
  output logic                                       rd_hold,
  output logic                                       fl_valid,
  input  logic                                       fl_ready,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]       fl_line,
  output logic [LINE_WORDS*BEAT_BYTES*8-1:0]         fl_data,
  output logic [LINE_WORDS*BEAT_BYTES-1:0]           fl_mask,
  output logic [2:0]                                 fl_ttype,
  output logic                                       fl_bypass,
  output logic                                       pending,
  output logic                                       busy
);
  localparam int WSEL_W     = $clog2(LINE_WORDS);
  localparam int TAG_W      = ADDR_W - WSEL_W;
  localparam int LINE_BYTES = LINE_WORDS * BEAT_BYTES;

  wg_state_e         state_q, state_d;
  logic [TAG_W-1:0]  tag_q;
  logic [2:0]        tt_q;
  logic              byp_q;

  logic [TAG_W-1:0]      wr_tag;
  logic [WSEL_W-1:0]     wr_word;
  logic                  tick, expire;
  logic                  probe_hit, conflict, flush_req;
  logic                  accept, is_ci, line_full, ack;
  logic [LINE_BYTES-1:0] mask_next;

  assign wr_tag  = wr_addr[ADDR_W-1:WSEL_W];
  assign wr_word = wr_addr[WSEL_W-1:0];
  assign is_ci   = (wr_ttype == TT_CI);

  wg_prescaler #(.PERIOD(PULSE_PERIOD)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  wg_timeout u_tmo (
    .clk    (clk),
    .rst    (rst),
    .load   (accept && !is_ci),
    .code   (cfg_tmo),
    .tick   (tick),
    .active (state_q == WG_GATHER),
    .expire (expire)
  );

  assign ack = (state_q == WG_FLUSH) && fl_ready;

  wg_line_buf #(.BEAT_BYTES(BEAT_BYTES), .LINE_WORDS(LINE_WORDS)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .clear     (ack),
    .wr_en     (accept),
    .word_sel  (wr_word),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .line_data (fl_data),
    .line_mask (fl_mask),
    .mask_next (mask_next)
  );

  assign line_full = &mask_next;
  assign probe_hit = rd_valid && (state_q != WG_IDLE) && (rd_line == tag_q);
  assign conflict  = wr_valid && (wr_tag != tag_q || wr_ttype != tt_q || is_ci);
  assign flush_req = (state_q == WG_GATHER) && (expire || probe_hit || conflict);

  always_comb begin
    case (state_q)
      WG_IDLE:   wr_ready = 1'b1;
      WG_GATHER: wr_ready = !flush_req;
      default:   wr_ready = 1'b0;
    endcase
  end

  assign accept = wr_valid && wr_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      WG_IDLE: begin
        if (accept) state_d = (is_ci || line_full) ? WG_FLUSH : WG_GATHER;
      end
      WG_GATHER: begin
        if (flush_req || (accept && line_full)) state_d = WG_FLUSH;
      end
      WG_FLUSH: begin
        if (fl_ready) state_d = WG_IDLE;
      end
      default: state_d = WG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WG_IDLE;
      tag_q   <= '0;
      tt_q    <= '0;
      byp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept && state_q == WG_IDLE) begin
        tag_q <= wr_tag;
        tt_q  <= wr_ttype;
        byp_q <= is_ci;
      end
    end
  end

  assign rd_hold   = probe_hit;
  assign fl_valid  = (state_q == WG_FLUSH);
  assign fl_line   = tag_q;
  assign fl_ttype  = tt_q;
  assign fl_bypass = byp_q;
  assign pending   = (state_q == WG_GATHER);
  assign busy      = (state_q != WG_IDLE);
endmodule

// File: rtl/wg_chk.sv
`timescale 1ns/1ps
module wg_chk #(
  parameter int ADDR_W       = 32,
  parameter int BEAT_BYTES   = 8,
  parameter int LINE_WORDS   = 4,
  parameter int PULSE_PERIOD = 64
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic [2:0]                           cfg_tmo,
  input logic                                 wr_valid,
  input logic                                 wr_ready,
  input logic [2:0]                           wr_ttype,
  input logic                                 rd_valid,
  input logic                                 rd_hold,
  input logic                                 fl_valid,
  input logic                                 fl_ready,
  input logic [ADDR_W-$clog2(LINE_WORDS)-1:0] fl_line,
  input logic [LINE_WORDS*BEAT_BYTES-1:0]     fl_mask,
  input logic                                 fl_bypass,
  input logic                                 pending,
  input logic                                 busy
);
  localparam int LIMIT = wg_pkg::MAX_TICKS * PULSE_PERIOD;

  logic [31:0] quiet_q;
  logic        tmo_on_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_q  <= '0;
      tmo_on_q <= 1'b0;
    end else if (wr_valid && wr_ready) begin
      quiet_q  <= '0;
      tmo_on_q <= (cfg_tmo != 3'd0);
    end else if (pending) begin
      quiet_q  <= quiet_q + 1;
    end else begin
      quiet_q  <= '0;
    end
  end

  // R10
  flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fl_valid && !fl_ready |=> fl_valid && $stable(fl_line) && $stable(fl_mask) && $stable(fl_bypass));

  // R10
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    fl_valid |-> !wr_ready && busy);

  // R5
  ci_flush_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid && wr_ready && wr_ttype == 3'd4 |=> fl_valid && fl_bypass);

  // R5
  bypass_width_chk: assert property (@(posedge clk) disable iff (rst)
    fl_valid && fl_bypass |-> $countones(fl_mask) <= BEAT_BYTES);

  // R9
  probe_flush_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && rd_hold && !fl_valid |=> fl_valid);

  // R6
  tmo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pending && tmo_on_q |-> quiet_q <= LIMIT);

  // R2
  state_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pending && fl_valid));
endmodule

bind write_gather wg_chk #(
  .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES), .LINE_WORDS(LINE_WORDS), .PULSE_PERIOD(PULSE_PERIOD)
) u_chk (.*);

// File: tb/tb_write_gather.sv
`timescale 1ns/1ps
module tb_write_gather;
  localparam int AW = 32, BB = 8, LW = 4, PP = 64;
  localparam int LB = BB * LW;

  logic clk = 0, rst = 1;
  logic [2:0] cfg_tmo = 3'd4;
  logic wr_valid = 0, wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [BB*8-1:0] wr_data = '0;
  logic [BB-1:0] wr_be = '0;
  logic [2:0] wr_ttype = '0;
  logic rd_valid = 0, rd_hold;
  logic [AW-3:0] rd_line = '0;
  logic fl_valid, fl_ready = 1;
  logic [AW-3:0] fl_line;
  logic [LB*8-1:0] fl_data;
  logic [LB-1:0] fl_mask;
  logic [2:0] fl_ttype;
  logic fl_bypass, pending, busy;

  write_gather #(.ADDR_W(AW), .BEAT_BYTES(BB), .LINE_WORDS(LW), .PULSE_PERIOD(PP)) dut (.*);

  always #4 clk = ~clk;   // 125 MHz

  int vectors = 0, miscompares = 0, seq = 0;
  string cur_req = "R1";
  bit last_ready;

  // behavioural reference state
  int m_st = 0, m_pre = 0, m_cnt = 0;
  bit m_en = 0, m_byp = 0;
  longint unsigned m_line = 0;
  bit [2:0] m_tt = 0;
  bit m_mask[LB];
  logic [7:0] m_byte[LB];

  function automatic int ticks_for(input bit [2:0] c);
    if (c == 0) return 0;
    if (c == 5) return 4;
    if (c == 6) return 8;
    if (c == 7) return 16;
    return 2;
  endfunction

  task automatic chk(input string name, input longint unsigned act, input longint unsigned exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, name, act, exp, $time);
    end
  endtask

  task automatic cycle();
    bit pulse, tmo, phit, conf, rdy, acc, full;
    longint unsigned wl;
    logic [LB-1:0] emask;
    #1;
    vectors++;
    pulse = (m_pre == PP - 1);
    wl    = wr_addr >> 2;
    tmo   = (m_st == 1) && pulse && m_en && (m_cnt == 1);
    phit  = rd_valid && (m_st != 0) && (rd_line == m_line);
    conf  = wr_valid && (wl != m_line || wr_ttype != m_tt || wr_ttype == 3'd4);
    rdy   = (m_st == 0) ? 1 : (m_st == 2) ? 0 : !(tmo || phit || conf);
    chk("wr_ready", wr_ready, rdy);
    chk("rd_hold", rd_hold, phit);
    chk("fl_valid", fl_valid, m_st == 2);
    chk("pending", pending, m_st == 1);
    chk("busy", busy, m_st != 0);
    if (m_st == 2) begin
      for (int i = 0; i < LB; i++) emask[i] = m_mask[i];
      chk("fl_line", fl_line, m_line);
      chk("fl_mask", fl_mask, emask);
      chk("fl_ttype", fl_ttype, m_tt);
      chk("fl_bypass", fl_bypass, m_byp);
      for (int i = 0; i < LB; i++)
        if (m_mask[i]) chk("fl_data byte", fl_data[i*8 +: 8], m_byte[i]);
    end
    last_ready = wr_ready;
    acc = wr_valid && rdy;
    if (m_st == 2) begin
      if (fl_ready) begin
        m_st = 0;
        for (int i = 0; i < LB; i++) m_mask[i] = 0;
      end
    end else if (m_st == 1 && !rdy) begin
      m_st = 2;
    end else if (acc) begin
      if (m_st == 0) begin
        m_line = wl; m_tt = wr_ttype; m_byp = (wr_ttype == 3'd4);
      end
      for (int b = 0; b < BB; b++)
        if (wr_be[b]) begin
          m_mask[(wr_addr % LW) * BB + b] = 1;
          m_byte[(wr_addr % LW) * BB + b] = wr_data[b*8 +: 8];
        end
      full = 1;
      for (int i = 0; i < LB; i++) if (!m_mask[i]) full = 0;
      if (wr_ttype != 3'd4) begin
        m_cnt = ticks_for(cfg_tmo); m_en = (cfg_tmo != 0);
      end
      m_st = (wr_ttype == 3'd4 || full) ? 2 : 1;
    end else if (m_st == 1 && pulse && m_en && m_cnt != 0) begin
      m_cnt--;
    end
    m_pre = (m_pre + 1) % PP;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [BB-1:0] be, input logic [2:0] tt);
    int guard = 0;
    wr_valid = 1; wr_addr = a; wr_be = be; wr_ttype = tt;
    wr_data = {a, 32'(seq * 32'h9e37 + 5)};
    seq++;
    do begin
      cycle();
      guard++;
    end while (!last_ready && guard < 5000);
    wr_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < LB; i++) begin m_mask[i] = 0; m_byte[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1"; tick(2);

    cur_req = "R3"; cfg_tmo = 4;
    for (int w = 0; w < LW; w++) put(32'h200 + w, 8'hff, 3'd0);
    tick(3);

    cur_req = "R2";
    put(32'h300, 8'h0f, 3'd0); put(32'h300, 8'hf0, 3'd0);
    put(32'h300, 8'h3c, 3'd0); put(32'h302, 8'h81, 3'd0);
    tick(140);

    cur_req = "R6";
    cfg_tmo = 5; put(32'h400, 8'h01, 3'd0); tick(100);
    put(32'h401, 8'h02, 3'd0); tick(300);
    cfg_tmo = 6; put(32'h410, 8'h04, 3'd0); tick(530);
    cfg_tmo = 7; put(32'h420, 8'h08, 3'd0); cfg_tmo = 0; tick(1050);

    cur_req = "R7";
    cfg_tmo = 1; put(32'h430, 8'h10, 3'd0); tick(140);
    cfg_tmo = 3; put(32'h440, 8'h20, 3'd0); tick(140);
    cfg_tmo = 2; put(32'h450, 8'h40, 3'd1); tick(140);

    cur_req = "R8";
    cfg_tmo = 0; put(32'h460, 8'hff, 3'd0); tick(3000);

    cur_req = "R9";
    rd_valid = 1; rd_line = 30'h999; tick(3);
    rd_line = 30'h460 >> 2; tick(3);
    rd_valid = 0; tick(2);

    cur_req = "R10";
    fl_ready = 0; cfg_tmo = 4;
    for (int w = 0; w < LW; w++) put(32'h500 + w, 8'hff, 3'd2);
    wr_valid = 1; wr_addr = 32'h600; wr_be = 8'h11; wr_ttype = 3'd0;
    rd_valid = 1; rd_line = 30'h500 >> 2;
    tick(6);
    rd_valid = 0; fl_ready = 1;
    put(32'h600, 8'h11, 3'd0); tick(2);

    cur_req = "R4";
    cfg_tmo = 0;
    put(32'h601, 8'h22, 3'd0);
    put(32'h700, 8'h33, 3'd0);
    put(32'h701, 8'h44, 3'd3);
    rd_valid = 1; rd_line = 30'h700 >> 2; tick(2); rd_valid = 0; tick(3);

    cur_req = "R5";
    put(32'h800, 8'h0f, 3'd4); tick(3);
    put(32'h900, 8'hf0, 3'd0);
    put(32'h900, 8'h0f, 3'd4); tick(4);
    fl_ready = 0; put(32'h904, 8'h01, 3'd4); tick(3); fl_ready = 1; tick(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog %s actual=running expected=done", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule